// File: doc/BRIEF.md
# Two-Operand Execute Unit with Flag-Driven Branch Resolution

This unit is the execute stage of a small 16-bit register machine. Each cycle it may accept one instruction word together with a source value and a destination value that an earlier stage has already fetched through the addressing modes. It works out which of three instruction classes the word belongs to: two-operand arithmetic, one-operand arithmetic, or flow of control. It then produces the value to write back to the destination and a write enable for it. It also reports whether a flow-of-control instruction redirects the program.

The format uses an expanding opcode. A four-bit major field selects one of the two-operand operations. The major value 1111 is withheld from that class and acts as an escape: the six bits that follow then pick a one-operand operation or a flow-of-control operation. Two condition flags, negative and zero, record the last arithmetic result. Conditional branches test those flags, and they do not alter them.

Top module: `alu_ex_unit`

## Requirements
- R1: While rst_n is low and after it rises, res_valid_o, result_o, wr_en_o, branch_taken_o and illegal_o are 0, flag_n_o is 0 and flag_z_o is 1.
- R2: An instruction presented with valid_i high at a rising clock edge produces exactly one result, and it appears on the outputs with res_valid_o high right after that edge. Back-to-back instructions are accepted every cycle.
- R3: When instr[15:12] is not 1111, it is a two-operand opcode: 0000 gives src, 0001 gives src+dst, 0010 gives dst-src, 0011 gives src&dst, and 0101 gives the low 16 bits of src*dst. Each of these drives wr_en_o high.
- R4: Opcode 0100 (compare) places dst-src on result_o and updates the flags from it, but keeps wr_en_o low.
- R5: With instr[15:12]=1111, the value instr[11:6] selects a one-operand operation on dst: 0 gives zero, 1 gives dst+1, 2 gives dst-1, 3 gives the two's-complement negation, and 4 gives the bitwise complement. Each of these drives wr_en_o high.
- R6: Every arithmetic operation, compare included, sets flag_n_o to bit 15 of its result and sets flag_z_o when the 16-bit result is zero.
- R7: With instr[15:12]=1111 and instr[5:0]=0, instr[11:6] values 8 to 13 are flow of control. They are: 8 unconditional jump, 9 taken on Z, 10 taken on !N&!Z, 11 taken on N, 12 taken on !N, 13 taken on N|Z. Each tests the flags left by earlier instructions. branch_taken_o is only ever high for these instructions.
- R8: Flow-of-control instructions leave both flags unchanged, keep wr_en_o low and give result_o 0.
- R9: Several patterns are illegal: two-operand opcodes 0110 to 1110, escaped codes other than 0 to 4 and 8 to 13, and flow codes with a nonzero instr[5:0]. An illegal pattern raises illegal_o, keeps wr_en_o and branch_taken_o low, gives result_o 0 and leaves the flags unchanged.
- R10: A cycle with valid_i low yields res_valid_o, wr_en_o, branch_taken_o and illegal_o low and result_o 0 in the next cycle, whatever instr_i, src_i and dst_i hold, and the flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 16 | Instruction word |
| src_i | input | 16 | Resolved source operand value |
| dst_i | input | 16 | Resolved destination operand value |
| res_valid_o | output | 1 | Result of an accepted instruction is present |
| result_o | output | 16 | Result value for the destination |
| wr_en_o | output | 1 | Destination must be written with result_o |
| branch_taken_o | output | 1 | Flow-of-control instruction redirects the program |
| illegal_o | output | 1 | Accepted word is not a defined instruction |
| flag_n_o | output | 1 | Negative flag of the last arithmetic result |
| flag_z_o | output | 1 | Zero flag of the last arithmetic result |

## Verification
Two functions of this block can fall in the same cycle. One is the flag commit of an arithmetic or compare instruction. The other is the evaluation of a conditional branch issued on the very next cycle, which must already see the committed flags. The bench provokes this by issuing each flag-setting instruction directly followed by one or two branches, with no idle cycle in between. It does so for operands that give negative, zero and positive results. A scoreboard model updates its own flags in issue order and judges branch_taken_o and the flag outputs against them. A run of illegal words and jumps sits between a flag setter and a branch to show that the branch still sees the older flags.

// File: rtl/alu_ex_pkg.sv
// Package: shared format constants and decoded-instruction types for the
// execute unit. Assumes a 16-bit instruction word with a 4-bit major field,
// a 6-bit minor field and a 6-bit specifier field.
package alu_ex_pkg;

    localparam int INSTR_W = 16;
    localparam int MAJOR_W = 4;
    localparam int SPEC_W  = 6;
    localparam int MINOR_W = INSTR_W - MAJOR_W - SPEC_W;

    localparam logic [MAJOR_W-1:0] ESCAPE = '1;

    typedef enum logic [3:0] {
        K_NONE, K_MOV, K_ADD, K_SUB, K_AND, K_CMP, K_MUL,
        K_CLR, K_INC, K_DEC, K_NEG, K_COM
    } alu_kind_e;

    typedef enum logic [2:0] {
        C_ALWAYS, C_EQ, C_GT, C_LT, C_GE, C_LE
    } cond_e;

    typedef struct packed {
        alu_kind_e kind;
        logic      is_alu;
        logic      writes;
        logic      is_flow;
        cond_e     cond;
        logic      illegal;
    } dec_t;

endpackage

// File: rtl/alu_ex_decode.sv
// Module: expanding-opcode decoder. It classifies a word as a two-operand,
// one-operand or flow-of-control instruction, or as illegal.
// Assumes: purely combinational; flow-of-control words carry no specifier.
module alu_ex_decode
    import alu_ex_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);

    logic [MAJOR_W-1:0] major;
    logic [MINOR_W-1:0] minor;
    logic [SPEC_W-1:0]  spec;

    assign major = instr_i[INSTR_W-1 -: MAJOR_W];
    assign minor = instr_i[SPEC_W +: MINOR_W];
    assign spec  = instr_i[SPEC_W-1:0];

    // Map the major field, or the escaped minor field, to a decoded operation.
    always_comb begin
        dec_o = '{kind: K_NONE, is_alu: 1'b0, writes: 1'b0,
                  is_flow: 1'b0, cond: C_ALWAYS, illegal: 1'b0};
        if (major != ESCAPE) begin
            dec_o.is_alu = 1'b1;
            dec_o.writes = 1'b1;
            case (major)
                4'd0:    dec_o.kind = K_MOV;
                4'd1:    dec_o.kind = K_ADD;
                4'd2:    dec_o.kind = K_SUB;
                4'd3:    dec_o.kind = K_AND;
                4'd4: begin
                    dec_o.kind   = K_CMP;
                    dec_o.writes = 1'b0;
                end
                4'd5:    dec_o.kind = K_MUL;
                default: begin
                    dec_o.is_alu  = 1'b0;
                    dec_o.writes  = 1'b0;
                    dec_o.illegal = 1'b1;
                end
            endcase
        end else begin
            case (minor)
                6'd0:  begin dec_o.kind = K_CLR; dec_o.is_alu = 1'b1; dec_o.writes = 1'b1; end
                6'd1:  begin dec_o.kind = K_INC; dec_o.is_alu = 1'b1; dec_o.writes = 1'b1; end
                6'd2:  begin dec_o.kind = K_DEC; dec_o.is_alu = 1'b1; dec_o.writes = 1'b1; end
                6'd3:  begin dec_o.kind = K_NEG; dec_o.is_alu = 1'b1; dec_o.writes = 1'b1; end
                6'd4:  begin dec_o.kind = K_COM; dec_o.is_alu = 1'b1; dec_o.writes = 1'b1; end
                6'd8:  begin dec_o.is_flow = 1'b1; dec_o.cond = C_ALWAYS; end
                6'd9:  begin dec_o.is_flow = 1'b1; dec_o.cond = C_EQ;     end
                6'd10: begin dec_o.is_flow = 1'b1; dec_o.cond = C_GT;     end
                6'd11: begin dec_o.is_flow = 1'b1; dec_o.cond = C_LT;     end
                6'd12: begin dec_o.is_flow = 1'b1; dec_o.cond = C_GE;     end
                6'd13: begin dec_o.is_flow = 1'b1; dec_o.cond = C_LE;     end
                default: dec_o.illegal = 1'b1;
            endcase
            if (dec_o.is_flow && (spec != '0)) begin
                dec_o.is_flow = 1'b0;
                dec_o.illegal = 1'b1;
            end
        end
    end

endmodule

// File: rtl/alu_ex_alu.sv
// Module: arithmetic datapath. It computes the result for every arithmetic,
// logical and compare operation.
// Assumes: W-bit two's-complement operands; the product keeps the low W bits.
module alu_ex_alu
    import alu_ex_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_kind_e    kind_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    output logic [W-1:0] res_o
);

    localparam logic [W-1:0] ONE = W'(1);

    // Select the operation result; compare yields the difference dst - src.
    always_comb begin
        case (kind_i)
            K_MOV:   res_o = src_i;
            K_ADD:   res_o = src_i + dst_i;
            K_SUB:   res_o = dst_i - src_i;
            K_AND:   res_o = src_i & dst_i;
            K_CMP:   res_o = dst_i - src_i;
            K_MUL:   res_o = src_i * dst_i;
            K_CLR:   res_o = '0;
            K_INC:   res_o = dst_i + ONE;
            K_DEC:   res_o = dst_i - ONE;
            K_NEG:   res_o = '0 - dst_i;
            K_COM:   res_o = ~dst_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_ex_cond.sv
// Module: branch predicate evaluator. It tests a condition against the
// stored negative and zero flags.
// Assumes: flags describe the last arithmetic result in two's complement.
module alu_ex_cond
    import alu_ex_pkg::*;
(
    input  cond_e cond_i,
    input  logic  neg_i,
    input  logic  zero_i,
    output logic  take_o
);

    // Evaluate the selected predicate.
    always_comb begin
        case (cond_i)
            C_ALWAYS: take_o = 1'b1;
            C_EQ:     take_o = zero_i;
            C_GT:     take_o = !neg_i && !zero_i;
            C_LT:     take_o = neg_i;
            C_GE:     take_o = !neg_i;
            C_LE:     take_o = neg_i || zero_i;
            default:  take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_ex_unit.sv
// Module: execute unit top. It decodes the word, computes the result, holds
// the condition flags and resolves branches, with one registered stage.
// Assumes: operands are already resolved; writeback and target arithmetic
// happen outside; synchronous active-low reset.
module alu_ex_unit
    import alu_ex_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  src_i,
    input  logic [DATA_W-1:0]  dst_i,
    output logic               res_valid_o,
    output logic [DATA_W-1:0]  result_o,
    output logic               wr_en_o,
    output logic               branch_taken_o,
    output logic               illegal_o,
    output logic               flag_n_o,
    output logic               flag_z_o
);

    localparam int SIGN_BIT = DATA_W - 1;

    dec_t              dec;
    logic [DATA_W-1:0] alu_res;
    logic              take;

    alu_ex_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    alu_ex_alu #(.W(DATA_W)) u_alu (
        .kind_i (dec.kind),
        .src_i  (src_i),
        .dst_i  (dst_i),
        .res_o  (alu_res)
    );

    alu_ex_cond u_cond (
        .cond_i (dec.cond),
        .neg_i  (flag_n_o),
        .zero_i (flag_z_o),
        .take_o (take)
    );

    // Register the per-instruction outputs; idle cycles clear them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o    <= 1'b0;
            result_o       <= '0;
            wr_en_o        <= 1'b0;
            branch_taken_o <= 1'b0;
            illegal_o      <= 1'b0;
        end else begin
            res_valid_o    <= valid_i;
            result_o       <= (valid_i && dec.is_alu) ? alu_res : '0;
            wr_en_o        <= valid_i && dec.writes;
            branch_taken_o <= valid_i && dec.is_flow && take;
            illegal_o      <= valid_i && dec.illegal;
        end
    end

    // Commit the condition flags after each accepted arithmetic operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n_o <= 1'b0;
            flag_z_o <= 1'b1;
        end else if (valid_i && dec.is_alu) begin
            flag_n_o <= alu_res[SIGN_BIT];
            flag_z_o <= (alu_res == '0);
        end
    end

endmodule

// File: rtl/alu_ex_unit_chk.sv
// Module: property checker for the execute unit. It watches the ports only
// and is attached to every instance of the unit by the bind below.
// Assumes: synchronous active-low reset and the fixed 16-bit word format.
module alu_ex_unit_chk
    import alu_ex_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               valid_i,
    input logic [INSTR_W-1:0] instr_i,
    input logic [DATA_W-1:0]  src_i,
    input logic [DATA_W-1:0]  dst_i,
    input logic               res_valid_o,
    input logic [DATA_W-1:0]  result_o,
    input logic               wr_en_o,
    input logic               branch_taken_o,
    input logic               illegal_o,
    input logic               flag_n_o,
    input logic               flag_z_o
);

    logic [MAJOR_W-1:0] major;
    logic [MINOR_W-1:0] minor;
    logic               flow_in;

    assign major   = instr_i[INSTR_W-1 -: MAJOR_W];
    assign minor   = instr_i[SPEC_W +: MINOR_W];
    assign flow_in = (major == ESCAPE) && (minor >= 6'd8) && (minor <= 6'd13)
                     && (instr_i[SPEC_W-1:0] == '0);

    // R1: reset leaves the zero flag set and the negative flag clear.
    a_r1_reset_flags: assert property (@(posedge clk)
        !rst_n |=> (flag_z_o && !flag_n_o && !res_valid_o));

    // R2: every accepted instruction yields a result in the next cycle.
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> res_valid_o);

    // R3: a move returns the source value presented one cycle earlier.
    a_r3_mov_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && major == 4'd0) |=> (result_o == $past(src_i) && wr_en_o));

    // R4: compare never requests a destination write.
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && major == 4'd4) |=> !wr_en_o);

    // R5: complement returns the inverted destination value.
    a_r5_com_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && major == ESCAPE && minor == 6'd4)
        |=> (result_o == ~$past(dst_i)));

    // R6: a written result is mirrored by the committed flags.
    a_r6_flags_track: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && wr_en_o)
        |-> (flag_z_o == (result_o == '0) && flag_n_o == result_o[DATA_W-1]));

    // R7: a redirect is never reported together with a write or a fault.
    a_r7_branch_alone: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken_o |-> (res_valid_o && !wr_en_o && !illegal_o));

    // R8: flow-of-control instructions keep both flags.
    a_r8_flow_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && flow_in) |=> ($stable(flag_n_o) && $stable(flag_z_o) && !wr_en_o));

    // R9: an illegal word leaves the flags and writes untouched.
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && !branch_taken_o && $stable(flag_n_o) && $stable(flag_z_o)));

    // R10: idle cycles produce no activity.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> (!wr_en_o && !branch_taken_o && !illegal_o && result_o == '0));

endmodule

bind alu_ex_unit alu_ex_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .valid_i        (valid_i),
    .instr_i        (instr_i),
    .src_i          (src_i),
    .dst_i          (dst_i),
    .res_valid_o    (res_valid_o),
    .result_o       (result_o),
    .wr_en_o        (wr_en_o),
    .branch_taken_o (branch_taken_o),
    .illegal_o      (illegal_o),
    .flag_n_o       (flag_n_o),
    .flag_z_o       (flag_z_o)
);

// File: tb/alu_ex_unit_tb_top.sv
// Bench: scoreboard for the execute unit. A driver task issues instructions
// and queues the expected outcome; a monitor pops and compares each result.
module alu_ex_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [15:0] src_i = '0;
    logic [15:0] dst_i = '0;
    logic        res_valid_o;
    logic [15:0] result_o;
    logic        wr_en_o;
    logic        branch_taken_o;
    logic        illegal_o;
    logic        flag_n_o;
    logic        flag_z_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] res;
        logic        wr;
        logic        br;
        logic        ill;
        logic        n;
        logic        z;
    } exp_t;

    exp_t q[$];
    logic m_n = 1'b0;
    logic m_z = 1'b1;

    always #5 clk = ~clk;

    alu_ex_unit dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .valid_i        (valid_i),
        .instr_i        (instr_i),
        .src_i          (src_i),
        .dst_i          (dst_i),
        .res_valid_o    (res_valid_o),
        .result_o       (result_o),
        .wr_en_o        (wr_en_o),
        .branch_taken_o (branch_taken_o),
        .illegal_o      (illegal_o),
        .flag_n_o       (flag_n_o),
        .flag_z_o       (flag_z_o)
    );

    function automatic logic [15:0] w2(input logic [3:0] op);
        return {op, 6'o12, 6'o34};
    endfunction

    function automatic logic [15:0] w1(input logic [5:0] code);
        return {4'hF, code, 6'o05};
    endfunction

    function automatic logic [15:0] w0(input logic [5:0] code);
        return {4'hF, code, 6'd0};
    endfunction

    // Record one check and report a failure line.
    task automatic check(input bit ok, input string tag, input string detail);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    // Driver: present one instruction and queue its expected outcome.
    task automatic issue(input string tag, input logic [15:0] ins,
                         input logic [15:0] s, input logic [15:0] d);
        exp_t        e;
        logic [15:0] r;
        logic        alu;
        logic [5:0]  mn;
        @(negedge clk);
        valid_i = 1'b1;
        instr_i = ins;
        src_i   = s;
        dst_i   = d;
        e.tag = tag; e.res = '0; e.wr = 1'b0; e.br = 1'b0; e.ill = 1'b0;
        r = '0; alu = 1'b0;
        mn = ins[11:6];
        if (ins[15:12] != 4'hF) begin
            alu = 1'b1; e.wr = 1'b1;
            case (ins[15:12])
                4'd0: r = s;
                4'd1: r = s + d;
                4'd2: r = d - s;
                4'd3: r = s & d;
                4'd4: begin r = d - s; e.wr = 1'b0; end
                4'd5: r = 16'((32'(s) * 32'(d)) & 32'hFFFF);
                default: begin alu = 1'b0; e.wr = 1'b0; e.ill = 1'b1; end
            endcase
        end else if (mn <= 6'd4) begin
            alu = 1'b1; e.wr = 1'b1;
            case (mn)
                6'd0: r = 16'd0;
                6'd1: r = d + 16'd1;
                6'd2: r = d - 16'd1;
                6'd3: r = (~d) + 16'd1;
                default: r = ~d;
            endcase
        end else if (mn >= 6'd8 && mn <= 6'd13 && ins[5:0] == 6'd0) begin
            case (mn)
                6'd8:  e.br = 1'b1;
                6'd9:  e.br = m_z;
                6'd10: e.br = !m_n && !m_z;
                6'd11: e.br = m_n;
                6'd12: e.br = !m_n;
                default: e.br = m_n || m_z;
            endcase
        end else begin
            e.ill = 1'b1;
        end
        if (alu) begin
            e.res = r;
            m_n = r[15];
            m_z = (r == 16'd0);
        end
        e.n = m_n;
        e.z = m_z;
        q.push_back(e);
    endtask

    // Drop valid for one cycle with disturbing inputs and check the idle outputs.
    task automatic idle_check();
        @(negedge clk);
        valid_i = 1'b0;
        instr_i = w2(4'd0);
        src_i   = 16'h0000;
        dst_i   = 16'h1234;
        @(negedge clk);
        check(!res_valid_o && result_o == 16'd0 && !wr_en_o && !branch_taken_o
              && !illegal_o && flag_n_o == m_n && flag_z_o == m_z, "R10",
              $sformatf("idle got v=%b r=%h w=%b b=%b i=%b n=%b z=%b expected all 0 n=%b z=%b",
                        res_valid_o, result_o, wr_en_o, branch_taken_o, illegal_o,
                        flag_n_o, flag_z_o, m_n, m_z));
    endtask

    // Monitor: compare every produced result with the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid_o) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "result without an issued instruction, expected none");
            end else begin
                exp_t e;
                e = q.pop_front();
                check(result_o == e.res && wr_en_o == e.wr && branch_taken_o == e.br
                      && illegal_o == e.ill && flag_n_o == e.n && flag_z_o == e.z, e.tag,
                      $sformatf("got r=%h w=%b b=%b i=%b n=%b z=%b expected r=%h w=%b b=%b i=%b n=%b z=%b",
                                result_o, wr_en_o, branch_taken_o, illegal_o, flag_n_o, flag_z_o,
                                e.res, e.wr, e.br, e.ill, e.n, e.z));
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R2", "watchdog expired, expected run to finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        check(!res_valid_o && result_o == 16'd0 && !wr_en_o && !branch_taken_o
              && !illegal_o && !flag_n_o && flag_z_o, "R1",
              $sformatf("in reset got v=%b r=%h w=%b b=%b i=%b n=%b z=%b expected 0,0,0,0,0,0,1",
                        res_valid_o, result_o, wr_en_o, branch_taken_o, illegal_o,
                        flag_n_o, flag_z_o));
        rst_n = 1'b1;
        @(negedge clk);
        check(!res_valid_o && !flag_n_o && flag_z_o, "R1",
              $sformatf("after reset got v=%b n=%b z=%b expected 0,0,1",
                        res_valid_o, flag_n_o, flag_z_o));

        // R7: branch on reset flags, then flag setter followed directly by branches.
        issue("R7", w0(6'd9), 16'h0, 16'h0);
        issue("R3", w2(4'd0), 16'h8000, 16'h0);
        issue("R7", w0(6'd11), 16'h0, 16'h0);
        issue("R7", w0(6'd12), 16'h0, 16'h0);
        idle_check();
        issue("R3", w2(4'd1), 16'd3, 16'd4);
        issue("R7", w0(6'd10), 16'h0, 16'h0);
        issue("R7", w0(6'd13), 16'h0, 16'h0);
        issue("R3", w2(4'd2), 16'd5, 16'd5);
        issue("R6", w0(6'd9), 16'h0, 16'h0);
        issue("R7", w0(6'd13), 16'h0, 16'h0);
        issue("R3", w2(4'd3), 16'hF0F0, 16'h3C3C);
        issue("R3", w2(4'd5), 16'h0100, 16'h0100);
        issue("R6", w0(6'd9), 16'h0, 16'h0);
        issue("R3", w2(4'd5), 16'd300, 16'd300);
        issue("R3", w2(4'd5), 16'hFFFF, 16'd2);
        // R4: compare in both directions, results not written.
        issue("R4", w2(4'd4), 16'd3, 16'd5);
        issue("R7", w0(6'd10), 16'h0, 16'h0);
        issue("R4", w2(4'd4), 16'd5, 16'd3);
        issue("R7", w0(6'd11), 16'h0, 16'h0);
        issue("R4", w2(4'd4), 16'd7, 16'd7);
        issue("R7", w0(6'd9), 16'h0, 16'h0);
        // R5: one-operand operations including wrap and the most negative value.
        issue("R5", w1(6'd0), 16'h1111, 16'hABCD);
        issue("R5", w1(6'd1), 16'h0, 16'hFFFF);
        issue("R5", w1(6'd2), 16'h0, 16'h0000);
        issue("R5", w1(6'd3), 16'h0, 16'h0001);
        issue("R5", w1(6'd3), 16'h0, 16'h8000);
        issue("R5", w1(6'd4), 16'h0, 16'h00FF);
        // R8: jumps keep flags; a branch after them still sees the old ones.
        issue("R6", w2(4'd0), 16'h0000, 16'h0);
        issue("R8", w0(6'd8), 16'h0, 16'h0);
        issue("R8", w0(6'd8), 16'h0, 16'h0);
        issue("R8", w0(6'd9), 16'h0, 16'h0);
        // R9: illegal words between a flag setter and a branch.
        issue("R6", w2(4'd0), 16'h9000, 16'h0);
        issue("R9", w2(4'd6), 16'h0, 16'h0);
        issue("R9", w2(4'd14), 16'h0, 16'h0);
        issue("R9", w1(6'd5), 16'h0, 16'h0);
        issue("R9", w0(6'd14), 16'h0, 16'h0);
        issue("R9", {4'hF, 6'd9, 6'd1}, 16'h0, 16'h0);
        issue("R9", w0(6'd11), 16'h0, 16'h0);
        idle_check();
        // R2: back-to-back stream of mixed operations, each followed by a branch.
        lf = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            logic [15:0] a;
            logic [15:0] b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b = (i % 5 == 0) ? a : lf;
            issue("R2", w2(4'(i % 6)), a, b);
            issue("R7", w0(6'(8 + (i % 6))), 16'h0, 16'h0);
        end
        idle_check();
        @(negedge clk);
        check(q.size() == 0, "R2",
              $sformatf("pending results got %0d expected 0", q.size()));
        done = 1'b1;
        summary();
        $finish;
    end

endmodule